// File: doc/BRIEF.md
# Cache and Write-Buffer Policy Controller

This block decides, for every data access, how a store is handled. Each of the eight memory regions carries one cacheable bit and one bufferable bit. The controller combines these bits with the protection-unit enable and the data-cache enable to get effective attributes. From the effective attributes it selects one of four write behaviours: direct (uncached and unbuffered), write-through, buffered-only or write-back.

Buffered stores enter a first-in first-out write buffer. The buffer drains, oldest first, to a simple memory write port with a valid/ready handshake. The region match and the cache hit test happen upstream and arrive as inputs.

The block produces three kinds of output:
- a processor stall;
- a cache-line update strobe that carries the new dirty-bit value;
- a grant for line fills.

A line fill is granted only when the write buffer is empty. A read in a buffered-only region stalls until the buffer has drained. The processor holds its request steady while the stall is high. The request counts as taken in the first cycle where the stall is low.

Top module: `wbuf_policy_ctrl`

## Requirements
- R1: The effective bufferable bit is buf_mask[region] AND prot_en. The effective cacheable bit is cache_mask[region] AND dcache_en AND prot_en. With prot_en low, every write is handled as a direct write.
- R2: A write with both effective bits clear is a direct write.
  - It waits until the buffer is empty, then drives the memory port itself with its own address, data and byte enables.
  - cpu_stall stays high until mem_ready is seen in a cycle where the buffer is empty.
  - It never enters the buffer.
- R3: A write with only the effective cacheable bit set (write-through) always enters the buffer. On a hit it also pulses line_upd with line_dirty = 0. On a miss line_upd stays low.
- R4: A write with both effective bits set (write-back) behaves by hit or miss.
  - On a hit it pulses line_upd with line_dirty = 1 and does not enter the buffer.
  - On a miss it enters the buffer and line_upd stays low.
- R5: A write with only the effective bufferable bit set enters the buffer. A read in such a region holds cpu_stall high while the buffer holds any entry.
- R6: A swap write (req_swap = 1) in a buffered-only region bypasses the buffer and is handled as a direct write. In the other classes the swap flag has no effect.
- R7: fill_grant is high only when fill_req is high and the buffer is empty.
- R8: The buffer holds 16 entries. A write that needs the buffer while it is full holds cpu_stall high and is taken in the cycle after an entry drains.
- R9: Buffer entries drain in arrival order. While mem_ready is low, mem_valid, mem_addr, mem_data and mem_be stay unchanged. A push and a pop may happen in the same cycle.
- R10: After reset the buffer is empty. mem_valid, cpu_stall, line_upd and fill_grant are low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Protection unit enable |
| dcache_en | input | 1 | Data cache enable |
| cache_mask | input | 8 | Per-region cacheable bits |
| buf_mask | input | 8 | Per-region bufferable bits |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_swap | input | 1 | Access is part of a swap |
| req_region | input | 3 | Matched region number |
| req_hit | input | 1 | Data cache hit |
| req_addr | input | 32 | Access address |
| req_data | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| fill_req | input | 1 | Line fill wanted |
| fill_grant | output | 1 | Line fill may start |
| cpu_stall | output | 1 | Processor stall |
| line_upd | output | 1 | Cache line write strobe |
| line_dirty | output | 1 | Dirty value written with line_upd |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_ready | input | 1 | Memory accepts the write |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked and judged.

The first pair is a new buffered store being accepted while the oldest entry leaves through the memory port. The bench holds a single entry, raises mem_ready and presents another store in the same cycle. It then expects the memory port to show only the newer address one cycle later.

The second pair is a line-fill request, or a buffered-only read, arriving while stores are still draining. The bench keeps fill_req high through a full drain. It expects fill_grant low in every cycle until the last pop, and high from the first cycle with an empty buffer.

// File: rtl/wbuf_policy_ctrl.sv
module wbuf_policy_ctrl #(
  parameter int REGIONS = 8,
  parameter int DEPTH = 16,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int RW = $clog2(REGIONS),
  localparam int PW = $clog2(DEPTH),
  localparam int BW = DW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prot_en,
  input  logic               dcache_en,
  input  logic [REGIONS-1:0] cache_mask,
  input  logic [REGIONS-1:0] buf_mask,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_swap,
  input  logic [RW-1:0]      req_region,
  input  logic               req_hit,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_data,
  input  logic [BW-1:0]      req_be,
  input  logic               fill_req,
  output logic               fill_grant,
  output logic               cpu_stall,
  output logic               line_upd,
  output logic               line_dirty,
  output logic               mem_valid,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_data,
  output logic [BW-1:0]      mem_be,
  input  logic               mem_ready
);

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [BW-1:0] q_be   [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   count;

  logic eff_b, eff_c, wr, direct, push_want, push, pop, empty, full, rd_drain;

  assign eff_b = buf_mask[req_region] & prot_en;
  assign eff_c = cache_mask[req_region] & dcache_en & prot_en;
  assign wr    = req_valid & req_write;

  assign empty = (count == '0);
  assign full  = (count == (PW+1)'(DEPTH));

  assign direct    = wr & ~eff_c & (~eff_b | req_swap);
  assign push_want = wr & ~direct & ~(eff_b & eff_c & req_hit);
  assign rd_drain  = req_valid & ~req_write & eff_b & ~eff_c & ~empty;

  assign cpu_stall = (push_want & full)
                   | (direct & ~(empty & mem_ready))
                   | rd_drain;

  assign push = push_want & ~full;
  assign pop  = ~empty & mem_ready;

  assign line_upd   = wr & eff_c & req_hit & ~cpu_stall;
  assign line_dirty = eff_b;

  assign fill_grant = fill_req & empty;

  assign mem_valid = ~empty | direct;
  assign mem_addr  = empty ? req_addr : q_addr[rd_ptr];
  assign mem_data  = empty ? req_data : q_data[rd_ptr];
  assign mem_be    = empty ? req_be   : q_be[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wr_ptr] <= req_addr;
      q_data[wr_ptr] <= req_data;
      q_be[wr_ptr]   <= req_be;
    end
  end

endmodule

module wbuf_policy_chk #(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW:0]   count,
  input logic          push,
  input logic          pop,
  input logic          line_upd,
  input logic          line_dirty,
  input logic          fill_grant,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr
);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PW+1)'(DEPTH));

  assert_full_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == (PW+1)'(DEPTH)) |-> !push);

  assert_fill_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_grant |-> (count == '0));

  assert_head_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && count != '0) |=> (mem_valid && $stable(mem_addr)));

  assert_grow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1));

  assert_wb_hit_no_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_upd && line_dirty) |-> !push);

endmodule

bind wbuf_policy_ctrl wbuf_policy_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .push(push), .pop(pop),
  .line_upd(line_upd), .line_dirty(line_dirty), .fill_grant(fill_grant),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/wbuf_policy_ctrl_test.sv
module wbuf_policy_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic prot_en = 0, dcache_en = 0;
  logic [7:0] cache_mask = 8'b0101_0110, buf_mask = 8'b0011_1100;
  logic req_valid = 0, req_write = 0, req_swap = 0, req_hit = 0;
  logic [2:0] req_region = 0;
  logic [31:0] req_addr = 0, req_data = 0;
  logic [3:0] req_be = 0;
  logic fill_req = 0, fill_grant, cpu_stall, line_upd, line_dirty;
  logic mem_valid, mem_ready = 0;
  logic [31:0] mem_addr, mem_data;
  logic [3:0] mem_be;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  wbuf_policy_ctrl uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic sw, input logic [2:0] r, input logic h,
                       input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    req_valid = 1; req_write = w; req_swap = sw; req_region = r; req_hit = h;
    req_addr = a; req_data = d; req_be = be;
  endtask

  function automatic logic [31:0] a_of(input int i); return 32'h1000 + i * 4; endfunction
  function automatic logic [31:0] d_of(input int i); return 32'hC0DE_0000 + i * 32'h111; endfunction
  function automatic logic [3:0]  b_of(input int i); return 4'(i + 1); endfunction

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 stall", cpu_stall, 0);
    chk("R10 mem_valid", mem_valid, 0);
    chk("R10 line_upd", line_upd, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R10 after release mem_valid", mem_valid, 0);
    chk("R10 fill_grant idle", fill_grant, 0);

    // Sweep over enables, regions, hit, swap, read/write
    for (int p = 0; p < 2; p++)
      for (int dc = 0; dc < 2; dc++)
        for (int r = 0; r < 8; r++)
          for (int h = 0; h < 2; h++)
            for (int sw = 0; sw < 2; sw++)
              for (int w = 0; w < 2; w++) begin
                logic eb, ec, dir, pw, lu;
                @(negedge clk);
                prot_en = p[0]; dcache_en = dc[0];
                eb = buf_mask[r] & p[0];
                ec = cache_mask[r] & dc[0] & p[0];
                dir = w[0] & ~ec & (~eb | sw[0]);
                pw = w[0] & ~dir & ~(eb & ec & h[0]);
                lu = w[0] & ec & h[0];
                drive(w[0], sw[0], 3'(r), h[0], 32'h8000 + r, 32'h55 + r, 4'hF);
                #1;
                chk($sformatf("R1 R2 R6 stall p=%0d dc=%0d r=%0d", p, dc, r), cpu_stall, dir);
                chk($sformatf("R2 R6 direct on port r=%0d sw=%0d", r, sw), mem_valid, dir);
                chk($sformatf("R3 R4 line_upd r=%0d h=%0d w=%0d", r, h, w), line_upd, lu);
                if (lu) chk($sformatf("R3 R4 dirty r=%0d", r), line_dirty, eb);
                @(negedge clk);
                req_valid = 0;
                #1;
                chk($sformatf("R3 R4 R5 pushed r=%0d h=%0d sw=%0d w=%0d", r, h, sw, w), mem_valid, pw);
                if (pw) begin
                  mem_ready = 1;
                  @(negedge clk);
                  mem_ready = 0;
                  #1;
                  chk("R9 drained", mem_valid, 0);
                end
              end

    prot_en = 1; dcache_en = 1;

    // Fill to 16 entries with write-back misses (region 2)
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      drive(1, 0, 3'd2, 0, a_of(i), d_of(i), b_of(i));
      #1;
      chk($sformatf("R8 no stall entry %0d", i), cpu_stall, 0);
    end
    @(negedge clk);
    drive(1, 0, 3'd2, 0, a_of(16), d_of(16), b_of(16));
    #1;
    chk("R8 full stalls", cpu_stall, 1);
    chk("R9 head addr", mem_addr, a_of(0));
    @(negedge clk); #1;
    chk("R8 still stalled", cpu_stall, 1);
    chk("R9 head held", mem_addr, a_of(0));
    chk("R9 head data held", mem_data, d_of(0));
    mem_ready = 1;
    #1;
    chk("R8 stall during pop cycle", cpu_stall, 1);
    @(negedge clk);
    mem_ready = 0;
    #1;
    chk("R8 taken after drain", cpu_stall, 0);
    chk("R9 next head", mem_addr, a_of(1));
    @(negedge clk);
    req_valid = 0;
    fill_req = 1;
    #1;
    chk("R7 fill held", fill_grant, 0);
    mem_ready = 1;
    for (int k = 1; k <= 16; k++) begin
      #1;
      chk($sformatf("R9 order addr %0d", k), mem_addr, a_of(k));
      chk($sformatf("R9 order data %0d", k), mem_data, d_of(k));
      chk($sformatf("R9 order be %0d", k), mem_be, b_of(k));
      chk($sformatf("R7 no grant %0d", k), fill_grant, 0);
      @(negedge clk);
    end
    mem_ready = 0;
    #1;
    chk("R9 empty", mem_valid, 0);
    chk("R7 grant when empty", fill_grant, 1);
    fill_req = 0;

    // Same-cycle push and pop (write-through miss, region 1)
    @(negedge clk);
    drive(1, 0, 3'd1, 0, 32'hAAA0, 32'h1, 4'h1);
    @(negedge clk);
    drive(1, 0, 3'd1, 0, 32'hBBB0, 32'h2, 4'h2);
    mem_ready = 1;
    #1;
    chk("R9 head before overlap", mem_addr, 32'hAAA0);
    chk("R3 no stall overlap", cpu_stall, 0);
    @(negedge clk);
    req_valid = 0; mem_ready = 0;
    #1;
    chk("R9 overlap leaves newer", mem_addr, 32'hBBB0);
    chk("R9 overlap valid", mem_valid, 1);
    mem_ready = 1;
    @(negedge clk);
    mem_ready = 0;
    #1;
    chk("R9 overlap drained", mem_valid, 0);

    // Buffered-only read drains first (region 3)
    @(negedge clk);
    drive(1, 0, 3'd3, 0, 32'hC000, 32'h3, 4'hF);
    @(negedge clk);
    drive(0, 0, 3'd3, 0, 32'hC100, 0, 0);
    #1;
    chk("R5 read stalls", cpu_stall, 1);
    mem_ready = 1;
    @(negedge clk);
    mem_ready = 0;
    #1;
    chk("R5 read released", cpu_stall, 0);
    @(negedge clk);
    req_valid = 0;

    // Direct write waits behind buffered entry (region 0)
    drive(1, 0, 3'd3, 0, 32'hD000, 32'h4, 4'hF);
    @(negedge clk);
    drive(1, 0, 3'd0, 0, 32'hE000, 32'h5, 4'h3);
    #1;
    chk("R2 direct stalls behind buffer", cpu_stall, 1);
    chk("R2 port shows buffered head", mem_addr, 32'hD000);
    mem_ready = 1;
    @(negedge clk); #1;
    chk("R2 port shows direct addr", mem_addr, 32'hE000);
    chk("R2 port shows direct be", mem_be, 4'h3);
    chk("R2 completes with ready", cpu_stall, 0);
    @(negedge clk);
    req_valid = 0; mem_ready = 0;
    #1;
    chk("R2 never buffered", mem_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule